// File: doc/BRIEF.md
# Converter Host Bus Interface

This block sits between a parallel microprocessor bus and the internal sequencer of a converter. The host side has four active-low strobes: chip select, read, write and calibrate. None of them is tied to the block clock. The block brings each strobe into the clock domain through a synchroniser, then finds the edges it needs. It raises a one-cycle conversion request when the write strobe rises while chip select is low. It raises a one-cycle calibration request when the calibrate strobe falls while chip select, read and write are all high.

Results come back from the sequencer as a valid/ready stream of 13-bit two's complement words. The block accepts every word in the cycle it is offered, stores it in an output latch and pulls the active-low interrupt low. A host read enables the data bus and sends the interrupt flag high again. A new conversion request or a calibration request also sends it high. The tri-state bus is modelled as an output-enable signal plus a data vector, and the data vector is zero whenever the bus is not enabled.

Top module: `hbi_top`

## Requirements
- R1: After reset `int_n` is 1, `bus_oe` is 0, `bus_data` is 0 and neither `conv_start` nor `cal_start` is asserted.
- R2: While `cs_n` is high, activity on `wr_n` and `rd_n` has no effect: no conversion request is made, `bus_oe` stays 0 and `int_n` keeps its value.
- R3: A rising edge of `wr_n` while `cs_n` is low produces exactly one cycle of `conv_start`, two clock cycles after the edge reaches the synchroniser. A falling edge of `wr_n` produces no request.
- R4: While both `cs_n` and `rd_n` are low (after synchronisation), `bus_oe` is 1 and `bus_data` equals the output latch. At all other times `bus_oe` is 0 and `bus_data` is 0.
- R5: `res_ready` is always 1. Every cycle with `res_valid` high loads `res_data` into the output latch and drives `int_n` low on the next clock edge.
- R6: An enabled read (`bus_oe` high) returns `int_n` to 1 on the next clock edge.
- R7: A `conv_start` or `cal_start` cycle returns `int_n` to 1 on the next edge. Clearing has priority over a completion in the same cycle, so the word is still latched but `int_n` stays 1.
- R8: A falling edge of `cal_n` produces a single-cycle `cal_start` only while `cs_n`, `rd_n` and `wr_n` are all high. With any of them low, the edge is ignored.
- R9: The output latch changes only on an accepted result beat. A read made while a conversion is in progress returns the previous result.
- R10: Result words pass through unchanged in 13-bit two's complement form: bit 12 is the sign, bit 11 the most significant magnitude bit and bit 0 the least significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low; its rising edge requests a conversion |
| cal_n | input | 1 | Calibrate strobe, active low; its falling edge requests calibration |
| conv_start | output | 1 | One-cycle conversion request to the sequencer |
| cal_start | output | 1 | One-cycle calibration request to the sequencer |
| res_valid | input | 1 | Result beat valid from the sequencer |
| res_ready | output | 1 | Result beat ready, constantly 1 |
| res_data | input | 13 | Result word, two's complement |
| bus_oe | output | 1 | Data bus output enable |
| bus_data | output | 13 | Data bus value, zero when not enabled |
| int_n | output | 1 | Active-low interrupt flag |

## Verification
The assertions assume the sequencer sends at most one result beat for each request. They also assume the host holds each strobe level for at least two clock cycles, so that the synchroniser never drops a pulse. The stimulus changes strobes only on falling clock edges and holds every level for three cycles or more. Result beats are single-cycle pulses, and one of them is timed to land in the same cycle as a conversion request so that the clear-over-set priority is exercised.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic cal_n;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= RST_VAL;
      else        stage[g] <= stage[g-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/hbi_strobe.sv
module hbi_strobe
  import hbi_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strb,
  output logic    conv_req,
  output logic    cal_req,
  output logic    rd_active
);
  strobe_t prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= strb;
  end

  logic selected;
  logic bus_quiet;
  assign selected  = !strb.cs_n;
  assign bus_quiet = strb.cs_n && strb.rd_n && strb.wr_n;

  assign conv_req  = selected && strb.wr_n && !prev.wr_n;
  assign cal_req   = bus_quiet && prev.cal_n && !strb.cal_n;
  assign rd_active = selected && !strb.rd_n;
endmodule

// File: rtl/hbi_result.sv
module hbi_result #(
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [DATA_W-1:0] word,
  input  logic              rd_active,
  input  logic              conv_req,
  input  logic              cal_req,
  output logic              oe,
  output logic [DATA_W-1:0] dout,
  output logic              irq_n
);
  logic [DATA_W-1:0] held;
  logic              clear;

  assign clear = rd_active || conv_req || cal_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (beat) held <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_n <= 1'b1;
    else if (clear) irq_n <= 1'b1;
    else if (beat)  irq_n <= 1'b0;
  end

  assign oe   = rd_active;
  assign dout = rd_active ? held : '0;
endmodule

// File: rtl/hbi_top.sv
module hbi_top
  import hbi_pkg::*;
#(
  parameter int DATA_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cal_n,
  output logic              conv_start,
  output logic              cal_start,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data,
  output logic              int_n
);
  strobe_t raw;
  strobe_t synced;
  logic    rd_active;
  logic    beat;

  assign raw = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, cal_n: cal_n};

  hbi_sync #(
    .WIDTH(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL({STROBE_W{1'b1}})
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .dout(synced)
  );

  hbi_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .strb(synced),
    .conv_req(conv_start), .cal_req(cal_start), .rd_active(rd_active)
  );

  assign res_ready = 1'b1;
  assign beat      = res_valid && res_ready;

  hbi_result #(.DATA_W(DATA_W)) u_result (
    .clk(clk), .rst_n(rst_n), .beat(beat), .word(res_data),
    .rd_active(rd_active), .conv_req(conv_start), .cal_req(cal_start),
    .oe(bus_oe), .dout(bus_data), .irq_n(int_n)
  );
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
  parameter int DATA_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              cal_start,
  input logic              res_valid,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_data,
  input logic              int_n
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r8_single_cal: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start && cal_start));

  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_data == '0);

  a_r5_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !bus_oe && !conv_start && !cal_start) |=> !int_n);

  a_r5_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(res_valid));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> int_n);

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start || cal_start) |=> int_n);

  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe) && !$past(res_valid)) |-> $stable(bus_data));
endmodule

bind hbi_top hbi_checker #(.DATA_W(DATA_W)) u_hbi_checker (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .cal_start(cal_start),
  .res_valid(res_valid), .bus_oe(bus_oe), .bus_data(bus_data), .int_n(int_n)
);

// File: tb/test_hbi_top.sv
module test_hbi_top;
  localparam int W = 13;
  localparam int EV_CONV = 0;
  localparam int EV_CAL = 1;
  localparam int EV_READ = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cal_n = 1'b1;
  logic res_valid = 1'b0;
  logic [W-1:0] res_data = '0;
  logic conv_start, cal_start, res_ready, bus_oe, int_n;
  logic [W-1:0] bus_data;

  always #10 clk = ~clk;

  hbi_top i_hbi_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cal_n(cal_n), .conv_start(conv_start), .cal_start(cal_start),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .bus_oe(bus_oe), .bus_data(bus_data), .int_n(int_n)
  );

  typedef struct { int kind; int data; string req; } ev_t;
  ev_t q[$];
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int kind, int data, string req);
    ev_t e;
    e.kind = kind; e.data = data; e.req = req;
    q.push_back(e);
  endtask

  function automatic void pop_cmp(int kind, int data);
    ev_t e;
    if (q.size() == 0) begin
      total++; fails++;
      $display("FAIL R2/R3/R8 unexpected event actual=%0d expected=none", kind);
      return;
    end
    e = q.pop_front();
    total++;
    if (e.kind != kind || (kind == EV_READ && e.data != data)) begin
      fails++;
      $display("FAIL %s actual=%0d/%0h expected=%0d/%0h", e.req, kind, data, e.kind, e.data);
    end
  endfunction

  // Monitor: pops expected events as the design produces them.
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (conv_start) pop_cmp(EV_CONV, 0);
      if (cal_start)  pop_cmp(EV_CAL, 0);
      if (bus_oe && !prev_oe) pop_cmp(EV_READ, int'(bus_data));
    end
    prev_oe <= bus_oe;
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(string req);
    cs_n = 1'b0; wr_n = 1'b0;
    wait_n(3);
    push(EV_CONV, 0, req);
    wr_n = 1'b1;
    wait_n(4);
    cs_n = 1'b1;
    wait_n(3);
  endtask

  task automatic bus_read(int exp, string req);
    push(EV_READ, exp, req);
    cs_n = 1'b0; rd_n = 1'b0;
    wait_n(4);
    chk(int_n == 1'b1, "R6 int_n during read", int_n, 1);
    rd_n = 1'b1; cs_n = 1'b1;
    wait_n(3);
  endtask

  task automatic complete(logic [W-1:0] d);
    res_valid = 1'b1; res_data = d;
    wait_n(1);
    res_valid = 1'b0;
    wait_n(1);
  endtask

  task automatic cal_pulse(string req);
    push(EV_CAL, 0, req);
    cal_n = 1'b0;
    wait_n(3);
    cal_n = 1'b1;
    wait_n(3);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset state
    chk(int_n == 1'b1, "R1 int_n", int_n, 1);
    chk(bus_oe == 1'b0, "R1 bus_oe", bus_oe, 0);
    chk(bus_data == '0, "R1 bus_data", bus_data, 0);
    chk(!conv_start && !cal_start, "R1 starts", {conv_start, cal_start}, 0);
    chk(res_ready == 1'b1, "R5 res_ready", res_ready, 1);

    // R5 completion sets interrupt, R4/R6 read returns word and clears
    complete(13'h00A5);
    chk(int_n == 1'b0, "R5 int_n after done", int_n, 0);
    bus_read(13'h00A5, "R4 read word");
    chk(int_n == 1'b1, "R6 int_n after read", int_n, 1);

    // R2 strobes ignored with chip select high
    complete(13'h1800);
    chk(int_n == 1'b0, "R5 int_n second done", int_n, 0);
    rd_n = 1'b0; wr_n = 1'b0;
    wait_n(3);
    chk(bus_oe == 1'b0, "R2 bus_oe cs high", bus_oe, 0);
    chk(bus_data == '0, "R2 bus_data cs high", bus_data, 0);
    wr_n = 1'b1;
    wait_n(4);
    rd_n = 1'b1;
    wait_n(3);
    chk(int_n == 1'b0, "R2 int_n kept", int_n, 0);

    // R3 write launches one request, R7 clears interrupt
    bus_write("R3 conversion request");
    chk(int_n == 1'b1, "R7 int_n after conv start", int_n, 1);

    // R9/R10 read during conversion returns previous negative word
    bus_read(13'h1800, "R9 R10 previous result");

    // R8 calibrate request clears interrupt (R7)
    complete(13'h07FF);
    chk(int_n == 1'b0, "R5 int_n third done", int_n, 0);
    cal_pulse("R8 calibration request");
    chk(int_n == 1'b1, "R7 int_n after cal", int_n, 1);

    // R8 calibrate ignored while rd_n low
    rd_n = 1'b0;
    wait_n(3);
    cal_n = 1'b0;
    wait_n(3);
    cal_n = 1'b1;
    wait_n(3);
    rd_n = 1'b1;
    wait_n(3);

    // R7 clear wins over a completion in the same cycle
    cs_n = 1'b0; wr_n = 1'b0;
    wait_n(3);
    push(EV_CONV, 0, "R3 second request");
    wr_n = 1'b1;
    wait_n(2);
    res_valid = 1'b1; res_data = 13'h1FFF;
    wait_n(1);
    res_valid = 1'b0;
    chk(int_n == 1'b1, "R7 clear beats done", int_n, 1);
    wait_n(2);
    cs_n = 1'b1;
    wait_n(3);
    bus_read(13'h1FFF, "R5 R10 word latched on collision");
    chk(bus_data == '0, "R4 bus_data after read", bus_data, 0);

    wait_n(4);
    chk(q.size() == 0, "R3 R8 pending events", q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule